// File: doc/BRIEF.md
# Restartable Pixel Clock Divider

This block derives a pixel clock from a fast input clock. The divide ratio comes from a 4-bit modulus code, and the available ratios are 3, 4, 5, 6, 8, 10, 12, 16 and 20. A 2-bit scale select adds a further factor of 1, 2 or 4 in front of the divider. The output has a 50% duty cycle for every ratio, including the odd ones. Half-period resolution comes from state changes on both edges of the fast clock. The output is the XOR of one flop clocked on the rising edge and one clocked on the falling edge, so it changes cleanly.

An enable pin starts the divider, and a polarity bit sets which level of the pin counts as active. When the enable becomes active, the output is realigned and its first falling edge comes a fixed, code-dependent number of fast-clock periods later. When the enable is released, the current output period completes and the output then stays high. A disable bit forces the output high and returns the divider to rest. Scale code 11 selects a board-test mode, in which a register bit sets the output level.

Top module: `pixclk_divider`

## Requirements
- R1: After reset the output is high and the divider is at rest.
- R2: The modulus code selects the ratio N as follows: 0000→3, 0001→4, 0010→4, 0011→5, 0100→6, 0101→8, 0110→8, 0111→10. When bit 3 is set, bit 2 has no effect: 1x00→12, 1x01→16, 1x10→16, 1x11→20.
- R3: Each output period lasts N·S fast-clock periods, with S the scale factor. It starts with a low half of N·S/2 fast periods and ends with a high half of the same length. For odd N·S the halves end on a falling clock edge.
- R4: The first falling output edge comes K·S fast periods after the rising clock edge that samples the enable becoming active. K is 2, 3.5, 3, 4.5, 3.5, 5.5, 5, 7, 6.5, 9.5, 9 and 12 for codes 0000 through 0111, then 1x00, 1x01, 1x10 and 1x11.
- R5: With en_pol = 0 the enable is active when en_pin is low. With en_pol = 1 it is active when en_pin is high.
- R6: When the enable goes inactive, the current output period finishes and the output then stays high.
- R7: scale_sel 00, 01 and 10 set S to 1, 2 and 4.
- R8: With scale_sel = 11 the output takes the value of test_lvl from the next rising clock edge on. The divider stays at rest, so an enable pulse seen in this mode starts nothing.
- R9: A high div_off drives the output high from the next rising clock edge and returns the divider to rest. Clearing div_off while the enable stays active starts no output activity. Only a new enable assertion restarts the divider.
- R10: A change of the modulus code takes effect only at a restart or at the end of a period. A period in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable / restart pin |
| en_pol | input | 1 | Active level of en_pin |
| mod_code | input | 4 | Modulus select code |
| scale_sel | input | 2 | Scale factor select; 11 selects test mode |
| div_off | input | 1 | Forces the divider to rest and the output high |
| test_lvl | input | 1 | Output level in test mode |
| clk_out | output | 1 | Divided clock |

## Verification
The bench builds the block with the default counter width of 8 bits. That width holds the longest period at scale 4 (160 half-steps) and the longest start delay (96 half-steps), so every modulus code and scale factor can be reached. A scoreboard predicts the exact time of each output edge from the restart latency and the half-period lengths, down to half a clock period. It covers the odd ratios, the bit-2 don't-care codes, mid-run code changes and both enable polarities.

// File: rtl/pixclk_divider.sv
module pixclk_divider #(
  parameter int CW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       en_pol,
  input  logic [3:0] mod_code,
  input  logic [1:0] scale_sel,
  input  logic       div_off,
  input  logic       test_lvl,
  output logic       clk_out
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;
  typedef struct packed {
    st_t           st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] h;
  } dv_t;

  localparam dv_t REST = '{st: S_IDLE, cnt: '0, h: CW'(4)};

  function automatic logic [CW-1:0] code_n(input logic [3:0] c);
    casez (c)
      4'b0000: code_n = CW'(3);
      4'b0001, 4'b0010: code_n = CW'(4);
      4'b0011: code_n = CW'(5);
      4'b0100: code_n = CW'(6);
      4'b0101, 4'b0110: code_n = CW'(8);
      4'b0111: code_n = CW'(10);
      4'b1?00: code_n = CW'(12);
      4'b1?01, 4'b1?10: code_n = CW'(16);
      default: code_n = CW'(20);
    endcase
  endfunction

  function automatic logic [CW-1:0] code_k2(input logic [3:0] c);
    casez (c)
      4'b0000: code_k2 = CW'(4);
      4'b0001: code_k2 = CW'(7);
      4'b0010: code_k2 = CW'(6);
      4'b0011: code_k2 = CW'(9);
      4'b0100: code_k2 = CW'(7);
      4'b0101: code_k2 = CW'(11);
      4'b0110: code_k2 = CW'(10);
      4'b0111: code_k2 = CW'(14);
      4'b1?00: code_k2 = CW'(13);
      4'b1?01: code_k2 = CW'(19);
      4'b1?10: code_k2 = CW'(18);
      default: code_k2 = CW'(24);
    endcase
  endfunction

  function automatic dv_t adv(input dv_t s, input logic act, input logic [CW-1:0] nh);
    dv_t r;
    r = s;
    case (s.st)
      S_WAIT:
        if (s.cnt == CW'(1)) begin
          r.st  = S_RUN;
          r.cnt = '0;
        end else r.cnt = s.cnt - CW'(1);
      S_RUN:
        if (s.cnt == (s.h << 1) - CW'(1)) begin
          r.cnt = '0;
          if (act) r.h = nh;
          else     r.st = S_IDLE;
        end else r.cnt = s.cnt + CW'(1);
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic lvl(input dv_t s);
    return (s.st == S_RUN) ? (s.cnt >= s.h) : 1'b1;
  endfunction

  dv_t           cur, s0, s1, s2;
  logic          act, act_q, start, test;
  logic          pe, ne, o0, o1, o1_q;
  logic [CW-1:0] sc, nh, nd;

  assign act   = ~(en_pin ^ en_pol);
  assign start = act & ~act_q;
  assign test  = (scale_sel == 2'b11);
  assign sc    = (scale_sel == 2'b01) ? CW'(2) : (scale_sel == 2'b10) ? CW'(4) : CW'(1);
  assign nh    = code_n(mod_code) * sc;
  assign nd    = code_k2(mod_code) * sc;

  always_comb begin
    if (div_off || test) s0 = REST;
    else if (start)      s0 = '{st: S_WAIT, cnt: nd, h: nh};
    else                 s0 = cur;
    s1 = adv(s0, act, nh);
    s2 = adv(s1, act, nh);
    o0 = test ? test_lvl : lvl(s0);
    o1 = test ? test_lvl : lvl(s1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= REST;
      act_q <= 1'b0;
      pe    <= 1'b1;
      o1_q  <= 1'b1;
    end else begin
      cur   <= s2;
      act_q <= act;
      pe    <= o0 ^ ne;
      o1_q  <= o1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ne <= 1'b0;
    else        ne <= o1_q ^ pe;
  end

  assign clk_out = pe ^ ne;

  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.st == S_IDLE && !$past(test)) |-> clk_out);

  p_run_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.st == S_RUN) |-> (cur.cnt < (cur.h << 1) && cur.h >= CW'(3)));

  p_restart_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !div_off && !test) |=> (cur.st == S_WAIT));

  p_test_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    test |=> (clk_out == $past(test_lvl) && cur.st == S_IDLE));

  p_off_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_off && !test) |=> (clk_out && cur.st == S_IDLE));

endmodule

// File: tb/pixclk_divider_tb.sv
`timescale 1ns/1ps
module pixclk_divider_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en_pin = 1'b1, en_pol = 1'b0, div_off = 1'b0, test_lvl = 1'b0;
  logic [3:0] mod_code = 4'b0001;
  logic [1:0] scale_sel = 2'b00;
  logic       clk_out;

  pixclk_divider u_dut (.clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_pol(en_pol),
    .mod_code(mod_code), .scale_sel(scale_sel), .div_off(div_off),
    .test_lvl(test_lvl), .clk_out(clk_out));

  always #4 clk = ~clk;

  typedef struct { time t; logic lvl; string tag; } ev_t;
  ev_t expq[$];
  int  n_run = 0, n_fail = 0;
  bit  mon_on = 0;

  function automatic int exp_n(input logic [3:0] c);
    casez (c)
      4'b0000: return 3;  4'b0001, 4'b0010: return 4;
      4'b0011: return 5;  4'b0100: return 6;
      4'b0101, 4'b0110: return 8;  4'b0111: return 10;
      4'b1?00: return 12; 4'b1?01, 4'b1?10: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic int exp_k2(input logic [3:0] c);
    casez (c)
      4'b0000: return 4;  4'b0001: return 7;  4'b0010: return 6;
      4'b0011: return 9;  4'b0100: return 7;  4'b0101: return 11;
      4'b0110: return 10; 4'b0111: return 14; 4'b1?00: return 13;
      4'b1?01: return 19; 4'b1?10: return 18; default: return 24;
    endcase
  endfunction

  function automatic int sclf(input logic [1:0] s);
    return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input time t, input logic l, input string tag);
    ev_t e;
    e.t = t; e.lvl = l; e.tag = tag;
    expq.push_back(e);
  endtask

  always @(clk_out) begin : monitor
    ev_t e;
    if (mon_on) begin
      if (expq.size() == 0) begin
        chk(0, "R6", "unexpected edge at time", longint'($time), -1);
      end else begin
        e = expq.pop_front();
        chk($time == e.t, e.tag, "edge time", longint'($time), longint'(e.t));
        chk(clk_out === e.lvl, e.tag, "edge level", longint'(clk_out), longint'(e.lvl));
      end
    end
  end

  task automatic settle_check(input string tag, input int cyc);
    repeat (cyc) @(negedge clk);
    chk(expq.size() == 0, tag, "pending edges", expq.size(), 0);
    chk(clk_out === 1'b1, tag, "parked level", longint'(clk_out), 1);
  endtask

  // Start the divider with code c1, switch to c2 after the first fall, run ncyc periods.
  task automatic run_case(input logic [3:0] c1, input logic [3:0] c2, input logic [1:0] sel,
                          input logic pol, input int ncyc, input string tag);
    int  h1, h2, d;
    time tp, tf, first_f, last_f;
    @(negedge clk);
    en_pol = pol; en_pin = ~pol; mod_code = c1; scale_sel = sel;
    repeat (4) @(negedge clk);
    h1 = exp_n(c1) * sclf(sel);
    h2 = exp_n(c2) * sclf(sel);
    d  = exp_k2(c1) * sclf(sel);
    en_pin = pol;
    tp = $time + 4;
    tf = tp + time'(d * 4);
    first_f = tf;
    last_f  = tf;
    for (int i = 0; i < ncyc; i++) begin
      int hh;
      hh = (i == 0) ? h1 : h2;
      push(tf, 1'b0, tag);
      push(tf + time'(hh * 4), 1'b1, tag);
      last_f = tf;
      tf = tf + time'(2 * hh * 4);
    end
    while ($time <= first_f) @(negedge clk);
    mod_code = c2;
    while ($time <= last_f) @(negedge clk);
    en_pin = ~pol;
    settle_check(tag, 2 * h2 + 40);
  endtask

  initial begin : watchdog
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : driver
    time tf;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_out === 1'b1, "R1", "reset level", longint'(clk_out), 1);
    mon_on = 1;

    run_case(4'b0000, 4'b0000, 2'b00, 1'b0, 3, "R2 R3 R4 R5 ratio3 low-active");
    run_case(4'b0001, 4'b0001, 2'b00, 1'b1, 3, "R4 R5 ratio4a high-active");
    run_case(4'b0010, 4'b0010, 2'b00, 1'b0, 2, "R4 ratio4b");
    run_case(4'b0011, 4'b0011, 2'b00, 1'b1, 3, "R3 ratio5 odd");
    run_case(4'b0100, 4'b0100, 2'b00, 1'b0, 2, "R2 ratio6");
    run_case(4'b0110, 4'b0110, 2'b00, 1'b0, 2, "R2 ratio8b");
    run_case(4'b0111, 4'b0111, 2'b00, 1'b1, 2, "R2 ratio10");
    run_case(4'b1100, 4'b1000, 2'b00, 1'b0, 2, "R2 ratio12 bit2 ignored");
    run_case(4'b1101, 4'b1101, 2'b00, 1'b0, 2, "R2 ratio16a bit2 ignored");
    run_case(4'b1010, 4'b1010, 2'b00, 1'b1, 2, "R4 ratio16b");
    run_case(4'b1011, 4'b1011, 2'b00, 1'b0, 2, "R4 ratio20");
    run_case(4'b0101, 4'b0101, 2'b01, 1'b0, 2, "R7 ratio8a scale2");
    run_case(4'b0011, 4'b0011, 2'b10, 1'b1, 2, "R7 ratio5 scale4");
    run_case(4'b0000, 4'b0111, 2'b00, 1'b0, 3, "R10 code change mid-run");
    run_case(4'b0111, 4'b0000, 2'b01, 1'b1, 3, "R10 code change scale2");

    // R9: disable while the output is low
    @(negedge clk);
    en_pol = 1'b0; en_pin = 1'b1; mod_code = 4'b1011; scale_sel = 2'b00;
    repeat (3) @(negedge clk);
    en_pin = 1'b0;
    tf = $time + 4 + 12 * 8;
    push(tf, 1'b0, "R9 start");
    while ($time <= tf) @(negedge clk);
    div_off = 1'b1;
    push($time + 4, 1'b1, "R9 forced high");
    repeat (10) @(negedge clk);
    div_off = 1'b0;
    settle_check("R9 no restart without new enable", 100);
    en_pin = 1'b1;
    run_case(4'b0010, 4'b0010, 2'b00, 1'b0, 1, "R9 clean restart after disable");

    // R8: test mode
    @(negedge clk);
    test_lvl = 1'b1;
    repeat (2) @(negedge clk);
    scale_sel = 2'b11;
    repeat (3) @(negedge clk);
    test_lvl = 1'b0; push($time + 4, 1'b0, "R8 test low");
    repeat (3) @(negedge clk);
    en_pol = 1'b0; en_pin = 1'b0;
    repeat (3) @(negedge clk);
    test_lvl = 1'b1; push($time + 4, 1'b1, "R8 test high");
    repeat (3) @(negedge clk);
    test_lvl = 1'b0; push($time + 4, 1'b0, "R8 test low again");
    repeat (40) @(negedge clk);
    chk(clk_out === 1'b0, "R8", "enable ignored in test mode", longint'(clk_out), 0);
    test_lvl = 1'b1; push($time + 4, 1'b1, "R8 test high again");
    repeat (3) @(negedge clk);
    en_pin = 1'b1;
    repeat (2) @(negedge clk);
    scale_sel = 2'b00;
    settle_check("R8 leave test mode", 40);

    mon_on = 0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule